// File: doc/BRIEF.md
# Sector Hamming ECC Engine

This block builds a 24-bit single-error-correcting parity code over a 512-byte flash sector while the bytes stream past it. Every data bit has a 12-bit address, `{byte index, bit index}`. The code has two 12-bit halves:

- The upper half holds, for each address bit, the parity of the set data bits whose address has that bit at one.
- The lower half holds the same parity for the set data bits whose address has that bit at zero.

Reading the code gives the packed halves, inverted, so that a fully erased sector (all bytes 0xFF) matches an erased stored code of all ones.

Several chip selects share the engine, and each keeps its own accumulation context. A write path streams the sector and then reads the code to store next to the data. A read path streams the sector back and then issues a compare with the stored 3-byte code. Byte 0 of the stored code sits in bits [7:0]. One cycle after the compare, the block reports one of four results, with a byte index and bit mask when a data bit can be repaired:

- clean,
- a repairable data-bit error,
- a flip inside the stored code only,
- uncorrectable.

The stream input is valid/ready. A byte transfers on a rising edge where both `in_valid` and `in_ready` are high, and goes to the context that `cs_sel` selects. `in_ready` falls once that context has taken a full sector or a byte marked end-of-sector. It stays low until a start-of-sector byte is offered, or until that context is cleared. The upstream source must hold its byte until `in_ready` is high. The result and code outputs have no back-pressure: each is a one-cycle pulse.

Top module: `hamming_sector_ecc`

## Requirements
- R1: After reset, `in_ready` is 1 and `res_vld` and `code_vld` are 0. Every context is empty, so reading any context's code returns 0xFFFFFF.
- R2: Data bits are addressed as `{byte index[8:0], bit index[2:0]}`, where byte index counts from the start-of-sector byte. `code_out[23:12]` is the inverted upper half: bit k is the parity of the set data bits whose address bit k is 1. `code_out[11:0]` is the inverted lower half, formed the same way over address bit k equal to 0.
- R3: A full sector of 0xFF bytes reads back code 0xFFFFFF and compares clean against a stored 0xFFFFFF.
- R4: A code read (`code_rd`) or a compare (`cmp_req`) empties the selected context. Its next code read returns 0xFFFFFF.
- R5: Each chip select has its own context. `restart[i]` empties context i only.
- R6: A byte accepted with `in_sof` high discards the context's previous contents and becomes byte 0 of a new sector.
- R7: After a context has accepted SECTOR_BYTES bytes, or a byte with `in_eof` high, `in_ready` is 0 for that context while `in_sof` is 0. An offered byte that is not accepted leaves the code unchanged.
- R8: With diff = computed code XOR stored code, a zero diff gives status 0 (clean), with `res_byte` and `res_mask` both 0.
- R9: If diff[23:12] XOR diff[11:0] is 0xFFF and diff[23:15] is below SECTOR_BYTES, the status is 1 (data repair). `res_byte` is then diff[23:15] and `res_mask` is 1 shifted left by diff[14:12].
- R10: If the XOR of the halves is 0xFFF but diff[23:15] is SECTOR_BYTES or more, the status is 3 (uncorrectable).
- R11: If diff has exactly one bit set, the status is 2 (stored-code flip), with `res_byte` and `res_mask` 0.
- R12: Any other nonzero diff gives status 3, with `res_byte` and `res_mask` 0.
- R13: `res_vld` is high exactly in the cycle after the edge that sampled `cmp_req`, and low otherwise. `code_vld` follows `code_rd` in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_sel | input | CS_W | Context used by stream, code read and compare |
| restart | input | NUM_CS | Per-context clear pulse |
| in_valid | input | 1 | Stream byte offered |
| in_ready | output | 1 | Selected context accepts a byte |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Byte is the first of a sector |
| in_eof | input | 1 | Byte is the last of a sector |
| code_rd | input | 1 | Read and clear the selected code |
| code_out | output | 24 | Inverted packed code, byte 0 in [7:0] |
| code_vld | output | 1 | `code_out` valid pulse |
| cmp_req | input | 1 | Compare the selected code with `cmp_stored`, then clear it |
| cmp_stored | input | 24 | Stored code read from the spare area |
| res_vld | output | 1 | Result valid pulse |
| res_status | output | 2 | 0 clean, 1 data repair, 2 code flip, 3 uncorrectable |
| res_byte | output | 9 | Byte index to repair |
| res_mask | output | 8 | Bit mask to XOR into that byte |

## Verification
The classifier is driven with diff patterns applied against an empty context:
- Zero tests the clean case.
- Exact half-complements at the first and last bit addresses and in the middle test the repair case.
- Single set bits at both ends of the word test the code-flip case.
- An all-ones diff and an arbitrary pattern are uncorrectable; the all-ones case has halves that cancel rather than complement.

A second instance with a 256-byte sector separates the in-range and out-of-range repair paths. End-to-end sectors are also used:
- a counting pattern, checked against a bit-by-bit model, which pins down the address-to-parity mapping;
- the same pattern with one flipped bit, which must come back as the right byte and mask;
- an erased sector, which proves the inversion;
- short and interleaved sectors, which expose leaks between contexts and the handling of start and end of sector.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int HALF_W = 12;
  localparam int CODE_W = 2 * HALF_W;
  localparam int RAW_W  = 28;
  localparam int IDX_W  = 9;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'd0,
    ST_FIXDATA  = 2'd1,
    ST_CODEFLIP = 2'd2,
    ST_BAD      = 2'd3
  } ecc_status_e;

  // Bits of a byte whose in-byte position has bit k set.
  function automatic logic [7:0] col_mask(input int k);
    logic [7:0] m;
    for (int j = 0; j < 8; j++) m[j] = ((j >> k) & 1) == 1;
    return m;
  endfunction

  // Raw layout: lower half at [11:0], upper half at [27:16].
  function automatic logic [CODE_W-1:0] pack_code(input logic [RAW_W-1:0] raw);
    return ~{raw[27:16], raw[11:0]};
  endfunction
endpackage

// File: rtl/ecc_byte_parity.sv
module ecc_byte_parity
  import ecc_pkg::*;
(
  input  logic [7:0]       data,
  input  logic [IDX_W-1:0] idx,
  output logic [RAW_W-1:0] contrib
);
  logic [HALF_W-1:0] up;
  logic [HALF_W-1:0] lo;
  logic              byte_par;

  assign byte_par = ^data;

  genvar k;
  generate
    for (k = 0; k < 3; k++) begin : g_col
      localparam logic [7:0] M = col_mask(k);
      assign up[k] = ^(data & M);
      assign lo[k] = ^(data & ~M);
    end
    for (k = 3; k < HALF_W; k++) begin : g_row
      assign up[k] = byte_par & idx[k-3];
      assign lo[k] = byte_par & ~idx[k-3];
    end
  endgenerate

  assign contrib = {up, 4'b0000, lo};
endmodule

// File: rtl/ecc_ctx.sv
module ecc_ctx
  import ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int CNT_W        = $clog2(SECTOR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic             sof,
  input  logic             eof,
  input  logic [7:0]       data,
  output logic [RAW_W-1:0] raw,
  output logic             full
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SECTOR_BYTES);

  logic [CNT_W-1:0] count;
  logic             fresh;
  logic [CNT_W-1:0] base_cnt;
  logic [CNT_W-1:0] next_cnt;
  logic [RAW_W-1:0] base_raw;
  logic [RAW_W-1:0] contrib;

  assign fresh    = clr | sof;
  assign base_cnt = fresh ? '0 : count;
  assign base_raw = fresh ? '0 : raw;
  assign next_cnt = base_cnt + CNT_W'(1);

  ecc_byte_parity u_par (
    .data    (data),
    .idx     (IDX_W'(base_cnt)),
    .contrib (contrib)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw   <= '0;
      count <= '0;
      full  <= 1'b0;
    end else if (take) begin
      raw   <= base_raw ^ contrib;
      count <= next_cnt;
      full  <= eof || (next_cnt == LAST);
    end else if (clr) begin
      raw   <= '0;
      count <= '0;
      full  <= 1'b0;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LAST);  // R7
  AST_NO_TAKE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (!full || sof || clr));  // R7
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !take) |=> (raw == '0 && count == '0 && !full));  // R4
endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
  import ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic [CODE_W-1:0] computed,
  input  logic [CODE_W-1:0] stored,
  output ecc_status_e       status,
  output logic [IDX_W-1:0]  byte_idx,
  output logic [7:0]        mask
);
  localparam logic [IDX_W:0] LIM = (IDX_W+1)'(SECTOR_BYTES);

  logic [CODE_W-1:0] diff;
  logic [HALF_W-1:0] syn;
  logic              single;

  assign diff   = computed ^ stored;
  assign syn    = diff[23:12] ^ diff[11:0];
  assign single = (diff & (diff - CODE_W'(1))) == '0;

  always_comb begin
    status   = ST_BAD;
    byte_idx = '0;
    mask     = '0;
    if (diff == '0) begin
      status = ST_CLEAN;
    end else if (&syn) begin
      if ({1'b0, diff[23:15]} < LIM) begin
        status   = ST_FIXDATA;
        byte_idx = diff[23:15];
        mask     = 8'h01 << diff[14:12];
      end
    end else if (single) begin
      status = ST_CODEFLIP;
    end
  end
endmodule

// File: rtl/hamming_sector_ecc.sv
module hamming_sector_ecc
  import ecc_pkg::*;
#(
  parameter int NUM_CS       = 4,
  parameter int SECTOR_BYTES = 512,
  parameter int CS_W         = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CS_W-1:0]   cs_sel,
  input  logic [NUM_CS-1:0] restart,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              code_rd,
  output logic [23:0]       code_out,
  output logic              code_vld,
  input  logic              cmp_req,
  input  logic [23:0]       cmp_stored,
  output logic              res_vld,
  output logic [1:0]        res_status,
  output logic [8:0]        res_byte,
  output logic [7:0]        res_mask
);
  localparam int CNT_W = $clog2(SECTOR_BYTES + 1);

  logic [RAW_W-1:0]  raw_a [NUM_CS];
  logic [NUM_CS-1:0] full_a;
  logic [CODE_W-1:0] sel_code;
  ecc_status_e       cl_status;
  logic [IDX_W-1:0]  cl_byte;
  logic [7:0]        cl_mask;
  logic              accept;

  assign in_ready = !full_a[cs_sel] || in_sof;
  assign accept   = in_valid && in_ready;

  genvar i;
  generate
    for (i = 0; i < NUM_CS; i++) begin : g_ctx
      logic hit;
      assign hit = (cs_sel == CS_W'(i));
      ecc_ctx #(.SECTOR_BYTES(SECTOR_BYTES), .CNT_W(CNT_W)) u_ctx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart[i] || (hit && (code_rd || cmp_req))),
        .take  (accept && hit),
        .sof   (in_sof),
        .eof   (in_eof),
        .data  (in_data),
        .raw   (raw_a[i]),
        .full  (full_a[i])
      );
    end
  endgenerate

  assign sel_code = pack_code(raw_a[cs_sel]);

  ecc_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_cls (
    .computed (sel_code),
    .stored   (cmp_stored),
    .status   (cl_status),
    .byte_idx (cl_byte),
    .mask     (cl_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_out   <= '0;
      code_vld   <= 1'b0;
      res_vld    <= 1'b0;
      res_status <= '0;
      res_byte   <= '0;
      res_mask   <= '0;
    end else begin
      code_vld <= code_rd;
      res_vld  <= cmp_req;
      if (code_rd) code_out <= sel_code;
      if (cmp_req) begin
        res_status <= cl_status;
        res_byte   <= cl_byte;
        res_mask   <= cl_mask;
      end
    end
  end

  AST_RES_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req |=> res_vld);  // R13
  AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_req |=> !res_vld);  // R13
  AST_FIX_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_status == ST_FIXDATA) |-> ($countones(res_mask) == 1));  // R9
  AST_FIX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_status == ST_FIXDATA) |-> ({1'b0, res_byte} < 10'(SECTOR_BYTES)));  // R10
  AST_CODEFLIP_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_status == ST_CODEFLIP) |-> (res_mask == '0 && res_byte == '0));  // R11
endmodule

// File: tb/sim_hamming_sector_ecc.sv
module sim_hamming_sector_ecc;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [1:0]  cs_sel;
  logic [3:0]  restart;
  logic        in_valid, in_sof, in_eof, code_rd, cmp_req;
  logic [7:0]  in_data;
  logic [23:0] cmp_stored;
  logic        in_ready, code_vld, res_vld;
  logic [23:0] code_out;
  logic [1:0]  res_status;
  logic [8:0]  res_byte;
  logic [7:0]  res_mask;
  logic        s_ready, s_code_vld, s_res_vld;
  logic [23:0] s_code_out;
  logic [1:0]  s_status;
  logic [8:0]  s_byte;
  logic [7:0]  s_mask;

  hamming_sector_ecc u0 (
    .clk(clk), .rst_n(rst_n), .cs_sel(cs_sel), .restart(restart),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .code_rd(code_rd),
    .code_out(code_out), .code_vld(code_vld), .cmp_req(cmp_req),
    .cmp_stored(cmp_stored), .res_vld(res_vld), .res_status(res_status),
    .res_byte(res_byte), .res_mask(res_mask));

  hamming_sector_ecc #(.SECTOR_BYTES(256)) u1 (
    .clk(clk), .rst_n(rst_n), .cs_sel(cs_sel), .restart(restart),
    .in_valid(in_valid), .in_ready(s_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .code_rd(code_rd),
    .code_out(s_code_out), .code_vld(s_code_vld), .cmp_req(cmp_req),
    .cmp_stored(cmp_stored), .res_vld(s_res_vld), .res_status(s_status),
    .res_byte(s_byte), .res_mask(s_mask));

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [512];

  // {small_dut, diff, status, byte, mask}
  localparam int NV = 11;
  localparam logic [43:0] VEC [NV] = '{
    {1'b0, 24'h000000, 2'd0, 9'd0,   8'h00},  // R8
    {1'b0, 24'h02BFD4, 2'd1, 9'd5,   8'h08},  // R9
    {1'b0, 24'hFFF000, 2'd1, 9'd511, 8'h80},  // R9
    {1'b0, 24'h000FFF, 2'd1, 9'd0,   8'h01},  // R9
    {1'b0, 24'h000001, 2'd2, 9'd0,   8'h00},  // R11
    {1'b0, 24'h800000, 2'd2, 9'd0,   8'h00},  // R11
    {1'b0, 24'h000003, 2'd3, 9'd0,   8'h00},  // R12
    {1'b0, 24'h123456, 2'd3, 9'd0,   8'h00},  // R12
    {1'b0, 24'hFFFFFF, 2'd3, 9'd0,   8'h00},  // R12
    {1'b1, 24'h96169E, 2'd3, 9'd0,   8'h00},  // R10
    {1'b1, 24'h7F8807, 2'd1, 9'd255, 8'h01}   // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_code(input int n);
    logic [11:0] up, lo, a;
    up = '0; lo = '0;
    for (int b = 0; b < n; b++)
      for (int j = 0; j < 8; j++)
        if (mem[b][j]) begin
          a  = {b[8:0], j[2:0]};
          up = up ^ a;
          lo = lo ^ ~a;
        end
    return ~{up, lo};
  endfunction

  task automatic put(input logic [1:0] cs, input logic [7:0] d, input logic s, input logic e);
    cs_sel = cs; in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic send(input logic [1:0] cs, input int n);
    for (int b = 0; b < n; b++) put(cs, mem[b], b == 0, b == n - 1);
  endtask

  task automatic rdcode(input logic [1:0] cs, output logic [23:0] c);
    cs_sel = cs; code_rd = 1'b1;
    @(negedge clk);
    code_rd = 1'b0;
    c = code_out;
  endtask

  task automatic compare(input logic [1:0] cs, input logic [23:0] st);
    cs_sel = cs; cmp_stored = st; cmp_req = 1'b1;
    @(negedge clk);
    cmp_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    logic [23:0] c, good;
    rst_n = 1'b0; cs_sel = '0; restart = '0; in_valid = 1'b0; in_sof = 1'b0;
    in_eof = 1'b0; in_data = '0; code_rd = 1'b0; cmp_req = 1'b0; cmp_stored = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ready", 32'(in_ready), 32'd1);
    chk("R1 res_vld", 32'(res_vld), 32'd0);
    chk("R1 code_vld", 32'(code_vld), 32'd0);
    rdcode(2'd2, c);
    chk("R1 empty code", 32'(c), 32'hFFFFFF);
    chk("R13 code_vld", 32'(code_vld), 32'd1);

    // Classifier table against empty context (computed = FFFFFF)
    for (int v = 0; v < NV; v++) begin
      compare(2'd0, ~VEC[v][42:19]);
      if (VEC[v][43]) begin
        chk("R9/R10 small sector status", 32'(s_status), 32'(VEC[v][18:17]));
        chk("R9 small sector byte", 32'(s_byte), 32'(VEC[v][16:8]));
        chk("R9 small sector mask", 32'(s_mask), 32'(VEC[v][7:0]));
      end else begin
        chk("R8/R9/R11/R12 status", 32'(res_status), 32'(VEC[v][18:17]));
        chk("R9/R11/R12 byte", 32'(res_byte), 32'(VEC[v][16:8]));
        chk("R9/R11/R12 mask", 32'(res_mask), 32'(VEC[v][7:0]));
      end
      chk("R13 res_vld high", 32'(res_vld), 32'd1);
    end
    @(negedge clk);
    chk("R13 res_vld pulse", 32'(res_vld), 32'd0);

    // R2 full pattern sector, R7 ready low and refused byte
    for (int b = 0; b < 512; b++) mem[b] = 8'(b * 37 + 5);
    send(2'd0, 512);
    cs_sel = 2'd0;
    #0;
    chk("R7 ready low when full", 32'(in_ready), 32'd0);
    put(2'd0, 8'h55, 1'b0, 1'b0);
    rdcode(2'd0, good);
    chk("R2 pattern code", 32'(good), 32'(ref_code(512)));

    // R9 end-to-end repair
    mem[100] = mem[100] ^ 8'h40;
    send(2'd0, 512);
    compare(2'd0, good);
    chk("R9 e2e status", 32'(res_status), 32'd1);
    chk("R9 e2e byte", 32'(res_byte), 32'd100);
    chk("R9 e2e mask", 32'(res_mask), 32'h40);
    mem[100] = mem[100] ^ 8'h40;

    // R3 erased sector, R4 clear on compare
    for (int b = 0; b < 512; b++) mem[b] = 8'hFF;
    send(2'd0, 512);
    compare(2'd0, 24'hFFFFFF);
    chk("R3 erased compare", 32'(res_status), 32'd0);
    rdcode(2'd0, c);
    chk("R4 cleared by compare", 32'(c), 32'hFFFFFF);
    send(2'd0, 512);
    rdcode(2'd0, c);
    chk("R3 erased code", 32'(c), 32'hFFFFFF);

    // R5 independent contexts
    mem[0] = 8'hA1; mem[1] = 8'hB2; mem[2] = 8'hC3;
    send(2'd1, 3);
    send(2'd2, 2);
    restart = 4'b0100;
    @(negedge clk);
    restart = '0;
    rdcode(2'd1, c);
    chk("R5 cs1 intact", 32'(c), 32'(ref_code(3)));
    rdcode(2'd2, c);
    chk("R5 cs2 restarted", 32'(c), 32'hFFFFFF);
    rdcode(2'd1, c);
    chk("R4 cleared by read", 32'(c), 32'hFFFFFF);

    // R6 sof restarts, R7 eof closes
    put(2'd3, 8'h12, 1'b1, 1'b0);
    put(2'd3, 8'h34, 1'b0, 1'b0);
    send(2'd3, 3);
    cs_sel = 2'd3;
    #0;
    chk("R7 ready low after eof", 32'(in_ready), 32'd0);
    put(2'd3, 8'h77, 1'b0, 1'b0);
    rdcode(2'd3, c);
    chk("R6 sof restart code", 32'(c), 32'(ref_code(3)));

    finish_run();
  end
endmodule